// File: doc/BRIEF.md
# Programmable interrupt line router

This block steers a single motherboard interrupt request onto one of sixteen interrupt controller input lines. An 8-bit configuration register selects the target. The register is written through a one-cycle write strobe and read back on a plain data output. Bit 7 of the register is a routing-off flag. Bits 3:0 are the target line number. Only eleven of the sixteen line numbers are legal targets. Five codes are reserved and route nowhere.

The sixteen outputs form a vector of routed requests. An interrupt controller would OR this vector with its own native sources. At most one bit of the vector is active at a time. The vector follows the request input combinationally, so the block adds no latency on the interrupt path.

Top module: `irq_route`

## Requirements
- R1: After reset the register reads 80h (routing off) and every bit of `irq_out` is 0.
- R2: When `wr_en` is high at a rising clock edge, the register takes `wr_data` at that edge, and `rd_data` shows the new value after it. When `wr_en` is low, the register keeps its value.
- R3: Register bits 6:4 always read as 0, whatever value was written to them.
- R4: While register bit 7 is 1, all sixteen `irq_out` bits are 0 for any routing code and any `irq_in`.
- R5: While bit 7 is 0 and bits 3:0 hold a code from 3 to 7, `irq_out[code]` equals `irq_in` and every other output bit is 0.
- R6: While bit 7 is 0 and bits 3:0 hold code 9, 10, 11, 12, 14 or 15, `irq_out[code]` equals `irq_in` and every other output bit is 0.
- R7: Codes 0, 1, 2, 8 and 13 are reserved. With any of them in bits 3:0, all output bits are 0 even when bit 7 is 0 and `irq_in` is 1.
- R8: `irq_out` responds to `irq_in` in the same cycle, with no register on that path, and never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| irq_in | input | 1 | Motherboard interrupt request |
| irq_out | output | 16 | Routed request vector, one bit per interrupt controller input |

## Verification
A register write is due on `rd_data` and `irq_out` one edge after the strobe. The bench drives the strobe at a falling edge and checks at the next falling edge, after the capturing rising edge. A change on `irq_in` is due with no edge at all. The bench changes it at a falling edge and samples a few nanoseconds later, within the same low phase, so a registered request path would fail. Random register values and request levels are compared against a bench model of the legal-code table. Directed sweeps cover every code, both settings of the off flag, and the reserved bits.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int unsigned LINES   = 16;
    localparam int unsigned SEL_W   = $clog2(LINES);
    localparam int unsigned REG_W   = 8;
    localparam logic [REG_W-1:0] CFG_RESET = 8'h80;

    typedef struct packed {
        logic             off;
        logic [2:0]       pad;
        logic [SEL_W-1:0] sel;
    } route_cfg_t;

    typedef logic [LINES-1:0] line_vec_t;

    // Legal target codes; others are reserved and route nowhere
    function automatic logic code_ok(input logic [SEL_W-1:0] c);
        case (c)
            4'd0, 4'd1, 4'd2, 4'd8, 4'd13: code_ok = 1'b0;
            default:                       code_ok = 1'b1;
        endcase
    endfunction

    function automatic route_cfg_t pack_cfg(input logic [REG_W-1:0] d);
        route_cfg_t c;
        c.off = d[7];
        c.pad = 3'b000;
        c.sel = d[SEL_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/irq_route_cfg.sv
module irq_route_cfg
    import irq_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output route_cfg_t       cfg
);

    route_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= route_cfg_t'(CFG_RESET);
        end else if (wr_en) begin
            cfg_q <= pack_cfg(wr_data);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/irq_route_dec.sv
module irq_route_dec
    import irq_route_pkg::*;
(
    input  route_cfg_t cfg,
    input  logic       req,
    output line_vec_t  lines
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        localparam logic [SEL_W-1:0] CODE = SEL_W'(i);
        if (code_ok(CODE)) begin : g_legal
            assign lines[i] = req & ~cfg.off & (cfg.sel == CODE);
        end else begin : g_rsvd
            assign lines[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic        irq_in,
    output logic [15:0] irq_out
);

    route_cfg_t cfg;
    line_vec_t  lines;

    irq_route_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    irq_route_dec u_dec (
        .cfg   (cfg),
        .req   (irq_in),
        .lines (lines)
    );

    assign rd_data = cfg;
    assign irq_out = lines;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [7:0]  wr_data,
    input logic [7:0]  rd_data,
    input logic        irq_in,
    input logic [15:0] irq_out
);

    // R2
    wr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == ($past(wr_data) & 8'h8F)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));

    // R3
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[6:4] == 3'b000);

    // R4
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[7] |-> (irq_out == 16'h0000));

    // R7
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[3:0] inside {4'd0, 4'd1, 4'd2, 4'd8, 4'd13}) |-> (irq_out == 16'h0000));

    // R5
    // R6
    legal_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[7] && !(rd_data[3:0] inside {4'd0, 4'd1, 4'd2, 4'd8, 4'd13}))
            |-> (irq_out[rd_data[3:0]] == irq_in));

    // R8
    single_line_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_out));

endmodule

bind irq_route irq_route_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_in  (irq_in),
    .irq_out (irq_out)
);

// File: tb/irq_route_tb.sv
`timescale 1ns/1ps
module irq_route_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        irq_in = 1'b0;
    logic [15:0] irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] model = 8'h80;

    always #10 clk = ~clk;

    irq_route u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_in  (irq_in),
        .irq_out (irq_out)
    );

    function automatic bit legal(input logic [3:0] c);
        return !(c == 4'd0 || c == 4'd1 || c == 4'd2 || c == 4'd8 || c == 4'd13);
    endfunction

    function automatic logic [15:0] want_out(input logic [7:0] r, input logic req);
        if (r[7] || !req || !legal(r[3:0])) return 16'h0000;
        return 16'h0001 << r[3:0];
    endfunction

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s irq_out actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // strobe at a falling edge, captured at the next rising edge, checked at the next falling edge
    task automatic write_reg(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = $urandom;
        model   = d & 8'h8F;
    endtask

    function automatic string tag_for(input logic [7:0] r);
        if (r[7]) return "R4";
        if (!legal(r[3:0])) return "R7";
        if (r[3]) return "R6";
        return "R5";
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk8("R1", rd_data, 8'h80);
        irq_in = 1'b1; #2;
        chk16("R1", irq_out, 16'h0000);
        irq_in = 1'b0;
        @(negedge clk);

        // R3 reserved bits dropped
        write_reg(8'h7B);
        chk8("R3", rd_data, 8'h0B);
        write_reg(8'hF5);
        chk8("R3", rd_data, 8'h85);

        // R2 hold without strobe
        wr_data = 8'h03;
        repeat (2) @(negedge clk);
        chk8("R2", rd_data, 8'h85);

        // sweep every code with routing on and off, both request levels
        for (int c = 0; c < 16; c++) begin
            for (int off = 0; off < 2; off++) begin
                write_reg({off[0], 3'b000, c[3:0]});
                chk8("R2", rd_data, model);
                for (int lv = 0; lv < 2; lv++) begin
                    irq_in = lv[0];
                    #2;
                    chk16(tag_for(model), irq_out, want_out(model, irq_in));
                    @(negedge clk);
                end
            end
        end

        // R8 same-cycle response: toggle request with no clock edge between
        write_reg(8'h0E);
        irq_in = 1'b1; #2;
        chk16("R8", irq_out, 16'h4000);
        irq_in = 1'b0; #2;
        chk16("R8", irq_out, 16'h0000);
        @(negedge clk);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                write_reg(8'($urandom));
                chk8("R2", rd_data, model);
            end
            irq_in = 1'($urandom);
            #2;
            chk16(tag_for(model), irq_out, want_out(model, irq_in));
            checks++;
            if ($countones(irq_out) > 1) begin
                fails++;
                $display("FAIL R8 irq_out actual=%h expected=at most one bit", irq_out);
            end
            @(negedge clk);
        end

        // R1 reset again from a routed state
        write_reg(8'h09);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model = 8'h80;
        chk8("R1", rd_data, 8'h80);
        irq_in = 1'b1; #2;
        chk16("R1", irq_out, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule